// File: doc/BRIEF.md
# Dual-Compare Timer Counter

A 16-bit up-counter that returns to zero when it reaches a programmable limit, so the limit value itself is never held. The limit of zero stands for the full 65536-state range. The timer can stop after one pass or run without end. It can raise a one-cycle interrupt pulse and always sets a sticky terminal flag that software clears by reading the status word.

The count advances on one of three sources: an internal tick enable, rising edges of an asynchronous input pin, or an external slow prescale tick. With the internal tick, the same pin either gates counting or, in retrigger mode, clears the count on each rising edge. A second compare value lets the output alternate between a high phase that counts to compare A and a low phase that counts to compare B. Without it, the output is high apart from a one-clock low pulse after each terminal count.

Top module: `dual_cmp_timer`

## Requirements
- R1: While running, a terminal event happens on an advancing cycle where count+1 (mod 2^16) equals the active compare value. The count is 0 after that edge, so a timer started at count c with compare m (c < m) has its first terminal event on the (m-c)-th edge after the start write, and then one every m edges.
- R2: A compare value of 0 makes the count run through 0xFFFF before it wraps to 0.
- R3: Single mode (CTRL bit0 = 0) clears running at the terminal event and leaves the count at 0. With dual compare on, it stops only at the end of the low phase. Continuous mode (bit0 = 1) keeps running.
- R4: With CTRL bit1 = 1, `irq` is high for the one cycle after the terminal edge. With bit1 = 0, `irq` stays low.
- R5: STATUS (address 5) reads bit0 = terminal flag, bit1 = running, bit2 = phase (1 = low phase). Reading STATUS clears the flag unless a terminal event happens in the same cycle. Read data and `rd_valid` appear one cycle after `rd_en`.
- R6: With the internal tick (CTRL bit2 = 0, bit4 = 0, bit5 = 0), the synchronized pin gates counting: high counts and low holds.
- R7: In retrigger mode (CTRL bit5 = 1, bit2 = 0), a synchronized rising edge of the pin resets a running count to 0, and the pin level does not gate.
- R8: With external clocking (CTRL bit2 = 1), the count advances once per pin rising edge, on the third clock edge after the pin rises, and the internal tick is ignored.
- R9: With prescale (CTRL bit4 = 1), the count advances on each cycle where `pre_tick` is high, and the internal tick and pin are ignored.
- R10: With dual compare (CTRL bit3 = 1), `wave_out` is high while counting to compare A and low while counting to compare B. Equal values give a 50% duty cycle.
- R11: With dual compare off, `wave_out` is low for exactly the one cycle after a terminal edge and high otherwise, including after reset.
- R12: A COUNT write (address 3) loads the count on its edge, whether running or stopped, and takes priority over counting.
- R13: Register map: 0 = CTRL[5:0] {retrigger, prescale, dual, ext_clk, irq_en, continuous}, 1 = compare A, 2 = compare B, 3 = COUNT, 4 = CMD (write bit0 start, bit1 stop, stop wins), 5 = STATUS. CTRL, compare and COUNT read back their values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tick_int | input | 1 | Internal count enable |
| pre_tick | input | 1 | External prescale tick, synchronous |
| tmr_pin | input | 1 | Asynchronous pin: clock, gate or retrigger |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 3 | Write address |
| wr_data | input | 16 | Write data |
| rd_en | input | 1 | Register read strobe |
| rd_addr | input | 3 | Read address |
| rd_data | output | 16 | Read data, one cycle after rd_en |
| rd_valid | output | 1 | Read data valid |
| irq | output | 1 | Terminal interrupt pulse |
| wave_out | output | 1 | Waveform output |

## Verification
Register reads return one cycle after the strobe. The scoreboard pushes each expected value when the read is issued and pops it at the falling edge where `rd_valid` shows. `irq` and the single-mode `wave_out` pulse follow the terminal edge by one cycle, so the bench counts falling edges from the start write and expects them exactly m-c edges later. Pin-driven effects take three clock edges, so the bench waits a fixed number of falling edges before it issues a stop and predicts the one extra increment that the stop edge adds. The dual-compare waveform is compared every cycle against a counter model kept in the bench.

// File: rtl/dct_pkg.sv
package dct_pkg;
  localparam int unsigned CTRL_BITS = 6;

  localparam logic [2:0] ADDR_CTRL   = 3'd0;
  localparam logic [2:0] ADDR_CMPA   = 3'd1;
  localparam logic [2:0] ADDR_CMPB   = 3'd2;
  localparam logic [2:0] ADDR_COUNT  = 3'd3;
  localparam logic [2:0] ADDR_CMD    = 3'd4;
  localparam logic [2:0] ADDR_STATUS = 3'd5;

  typedef struct packed {
    logic retrig;
    logic prescale;
    logic dual;
    logic ext_clk;
    logic irq_en;
    logic cont;
  } ctrl_t;
endpackage

// File: rtl/dct_sync_edge.sv
module dct_sync_edge #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic pin_i,
  output logic level_o,
  output logic rise_o
);
  logic [STAGES-1:0] chain_q;
  logic              last_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      chain_q <= '0;
      last_q  <= 1'b0;
    end else begin
      chain_q[0] <= pin_i;
      for (int i = 1; i < STAGES; i++) chain_q[i] <= chain_q[i-1];
      last_q <= chain_q[STAGES-1];
    end
  end

  assign level_o = chain_q[STAGES-1];
  assign rise_o  = chain_q[STAGES-1] & ~last_q;

  // R8: an edge indication lasts a single cycle
  assert_rise_single_R8: assert property (@(posedge clk) disable iff (!rst_n)
    rise_o |=> !rise_o);
endmodule

// File: rtl/dct_tick_sel.sv
module dct_tick_sel (
  input  logic tick_int,
  input  logic pre_tick,
  input  logic pin_level,
  input  logic pin_rise,
  input  logic sel_ext,
  input  logic sel_pre,
  input  logic sel_retrig,
  output logic adv_o,
  output logic retrig_o
);
  always_comb begin
    if (sel_pre)       adv_o = pre_tick;
    else if (sel_ext)  adv_o = pin_rise;
    else               adv_o = tick_int & (sel_retrig | pin_level);
  end
  assign retrig_o = sel_retrig & ~sel_ext & pin_rise;
endmodule

// File: rtl/dct_count_core.sv
module dct_count_core #(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         mode_cont,
  input  logic         mode_irq,
  input  logic         mode_dual,
  input  logic [W-1:0] cmp_a,
  input  logic [W-1:0] cmp_b,
  input  logic         cnt_wr,
  input  logic [W-1:0] cnt_wdata,
  input  logic         start,
  input  logic         stop,
  input  logic         adv,
  input  logic         retrig_rst,
  output logic [W-1:0] count_o,
  output logic         running_o,
  output logic         phase_o,
  output logic         hit_o,
  output logic         irq_o
);
  function automatic logic [W-1:0] step_up(input logic [W-1:0] c);
    return c + 1'b1;
  endfunction

  function automatic logic at_limit(input logic [W-1:0] c, input logic [W-1:0] lim);
    return step_up(c) == lim;
  endfunction

  logic [W-1:0] count_q;
  logic         running_q, phase_q, irq_q;
  logic [W-1:0] cmp_act;
  logic         moving, hit, halt_now;

  assign cmp_act  = (mode_dual && phase_q) ? cmp_b : cmp_a;
  assign moving   = running_q && adv && !cnt_wr && !retrig_rst;
  assign hit      = moving && at_limit(count_q, cmp_act);
  assign halt_now = hit && !mode_cont && (!mode_dual || phase_q);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      count_q   <= '0;
      running_q <= 1'b0;
      phase_q   <= 1'b0;
      irq_q     <= 1'b0;
    end else begin
      if (cnt_wr)                       count_q <= cnt_wdata;
      else if (running_q && retrig_rst) count_q <= '0;
      else if (moving)                  count_q <= hit ? '0 : step_up(count_q);

      if (stop)          running_q <= 1'b0;
      else if (start)    running_q <= 1'b1;
      else if (halt_now) running_q <= 1'b0;

      if (!mode_dual) phase_q <= 1'b0;
      else if (hit)   phase_q <= ~phase_q;

      irq_q <= hit && mode_irq;
    end
  end

  assign count_o   = count_q;
  assign running_o = running_q;
  assign phase_o   = phase_q;
  assign hit_o     = hit;
  assign irq_o     = irq_q;

  // R1: the count is back at zero after a terminal event
  assert_wrap_zero_R1: assert property (@(posedge clk) disable iff (!rst_n)
    hit |=> count_q == '0);
  // R3: single mode stops at the end of its final phase
  assert_single_halt_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (hit && !mode_cont && (!mode_dual || phase_q) && !start) |=> !running_q);
  // R4: an enabled terminal event yields a pulse
  assert_irq_follows_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (hit && mode_irq) |=> irq_q);
  // R4: no pulse without a terminal event
  assert_irq_cause_R4: assert property (@(posedge clk) disable iff (!rst_n)
    irq_q |-> $past(hit));
  // R10: every dual-mode terminal event flips the phase
  assert_phase_flip_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (hit && mode_dual) |=> (phase_q != $past(phase_q)) || !mode_dual);
endmodule

// File: rtl/dct_wave_gen.sv
module dct_wave_gen (
  input  logic clk,
  input  logic rst_n,
  input  logic mode_dual,
  input  logic phase,
  input  logic hit,
  output logic wave_o
);
  logic low_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) low_q <= 1'b0;
    else        low_q <= hit;
  end

  assign wave_o = mode_dual ? ~phase : ~low_q;

  // R11: without a terminal event the single-compare output returns high
  assert_low_one_clock_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (!mode_dual && !hit) |=> (wave_o || mode_dual));
  // R11: a terminal event drives the single-compare output low
  assert_low_after_hit_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (!mode_dual && hit) |=> (!wave_o || mode_dual));
endmodule

// File: rtl/dual_cmp_timer.sv
module dual_cmp_timer #(
  parameter int W           = 16,
  parameter int ADDR_W      = 3,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tick_int,
  input  logic              pre_tick,
  input  logic              tmr_pin,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [W-1:0]      wr_data,
  input  logic              rd_en,
  input  logic [ADDR_W-1:0] rd_addr,
  output logic [W-1:0]      rd_data,
  output logic              rd_valid,
  output logic              irq,
  output logic              wave_out
);
  import dct_pkg::*;

  localparam int PAD_CTRL = W - CTRL_BITS;
  localparam int PAD_STAT = W - 3;

  ctrl_t        ctrl_q;
  logic [W-1:0] cmpa_q, cmpb_q;
  logic         flag_q;
  logic [W-1:0] rd_data_q;
  logic         rd_valid_q;

  logic         pin_level, pin_rise, adv, retrig_rst;
  logic [W-1:0] count;
  logic         running, phase, hit;
  logic         cnt_wr, start, stop, stat_rd;

  assign cnt_wr  = wr_en && (wr_addr == ADDR_COUNT);
  assign start   = wr_en && (wr_addr == ADDR_CMD) && wr_data[0];
  assign stop    = wr_en && (wr_addr == ADDR_CMD) && wr_data[1];
  assign stat_rd = rd_en && (rd_addr == ADDR_STATUS);

  dct_sync_edge #(.STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst_n(rst_n), .pin_i(tmr_pin),
    .level_o(pin_level), .rise_o(pin_rise)
  );

  dct_tick_sel u_sel (
    .tick_int(tick_int), .pre_tick(pre_tick),
    .pin_level(pin_level), .pin_rise(pin_rise),
    .sel_ext(ctrl_q.ext_clk), .sel_pre(ctrl_q.prescale), .sel_retrig(ctrl_q.retrig),
    .adv_o(adv), .retrig_o(retrig_rst)
  );

  dct_count_core #(.W(W)) u_core (
    .clk(clk), .rst_n(rst_n),
    .mode_cont(ctrl_q.cont), .mode_irq(ctrl_q.irq_en), .mode_dual(ctrl_q.dual),
    .cmp_a(cmpa_q), .cmp_b(cmpb_q),
    .cnt_wr(cnt_wr), .cnt_wdata(wr_data),
    .start(start), .stop(stop), .adv(adv), .retrig_rst(retrig_rst),
    .count_o(count), .running_o(running), .phase_o(phase),
    .hit_o(hit), .irq_o(irq)
  );

  dct_wave_gen u_wave (
    .clk(clk), .rst_n(rst_n), .mode_dual(ctrl_q.dual),
    .phase(phase), .hit(hit), .wave_o(wave_out)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctrl_q <= '0;
      cmpa_q <= '0;
      cmpb_q <= '0;
    end else if (wr_en) begin
      case (wr_addr)
        ADDR_CTRL: ctrl_q <= ctrl_t'(wr_data[CTRL_BITS-1:0]);
        ADDR_CMPA: cmpa_q <= wr_data;
        ADDR_CMPB: cmpb_q <= wr_data;
        default:   ;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       flag_q <= 1'b0;
    else if (hit)     flag_q <= 1'b1;
    else if (stat_rd) flag_q <= 1'b0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rd_data_q  <= '0;
      rd_valid_q <= 1'b0;
    end else begin
      rd_valid_q <= rd_en;
      if (rd_en) begin
        case (rd_addr)
          ADDR_CTRL:   rd_data_q <= {{PAD_CTRL{1'b0}}, ctrl_q};
          ADDR_CMPA:   rd_data_q <= cmpa_q;
          ADDR_CMPB:   rd_data_q <= cmpb_q;
          ADDR_COUNT:  rd_data_q <= count;
          ADDR_STATUS: rd_data_q <= {{PAD_STAT{1'b0}}, phase, running, flag_q};
          default:     rd_data_q <= '0;
        endcase
      end
    end
  end

  assign rd_data  = rd_data_q;
  assign rd_valid = rd_valid_q;

  // R5: a terminal event always leaves the flag set
  assert_flag_set_R5: assert property (@(posedge clk) disable iff (!rst_n)
    hit |=> flag_q);
  // R5: read data is valid exactly one cycle after the strobe
  assert_rd_latency_R5: assert property (@(posedge clk) disable iff (!rst_n)
    rd_en |=> rd_valid);
  // R12: a count write lands on its edge
  assert_count_load_R12: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_wr |=> count == $past(wr_data));
endmodule

// File: tb/dual_cmp_timer_tb_top.sv
module dual_cmp_timer_tb_top;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic tick_int = 1'b1, pre_tick = 1'b0, tmr_pin = 1'b0;
  logic wr_en = 1'b0, rd_en = 1'b0;
  logic [2:0] wr_addr = '0, rd_addr = '0;
  logic [15:0] wr_data = '0;
  logic [15:0] rd_data;
  logic rd_valid, irq, wave_out;

  int n_cmp = 0, n_bad = 0;
  bit done = 1'b0;

  typedef struct { logic [15:0] exp; bit chk; string tag; } item_t;
  item_t sb_q[$];

  always #5 clk = ~clk;

  dual_cmp_timer dut_i (
    .clk(clk), .rst_n(rst_n), .tick_int(tick_int), .pre_tick(pre_tick),
    .tmr_pin(tmr_pin), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .rd_en(rd_en), .rd_addr(rd_addr), .rd_data(rd_data), .rd_valid(rd_valid),
    .irq(irq), .wave_out(wave_out)
  );

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    n_cmp++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", tag, act, exp);
    end
  endtask

  // all driver tasks are entered and left at a falling edge
  task automatic wr(input logic [2:0] a, input logic [15:0] d);
    wr_en = 1'b1; wr_addr = a; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic rd(input logic [2:0] a, input logic [15:0] e, input bit chk, input string tag);
    item_t it;
    it.exp = e; it.chk = chk; it.tag = tag;
    sb_q.push_back(it);
    rd_en = 1'b1; rd_addr = a;
    @(negedge clk);
    rd_en = 1'b0;
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic wait_irq(output int n);
    n = 0;
    do begin @(negedge clk); n++; end while (!irq && n < 40);
  endtask

  // monitor: pops expected read values as results appear
  initial begin
    forever begin
      @(negedge clk);
      if (rd_valid) begin
        if (sb_q.size() == 0) check(1'b0, "unexpected read", rd_data, 0);
        else begin
          item_t it;
          it = sb_q.pop_front();
          if (it.chk) check(rd_data === it.exp, it.tag, rd_data, it.exp);
        end
      end
    end
  end

  localparam logic [2:0] A_CTRL = 3'd0, A_CA = 3'd1, A_CB = 3'd2,
                         A_CNT = 3'd3, A_CMD = 3'd4, A_ST = 3'd5;
  localparam logic [15:0] GO = 16'h1, HALT = 16'h2;

  initial begin
    int n, highs;
    logic [15:0] mcnt;
    bit mph, seen;
    logic [15:0] ca, cb;
    idle(5);
    rst_n = 1'b1;
    idle(2);

    // reset state
    check(wave_out === 1'b1, "R11 wave after reset", wave_out, 1);
    check(irq === 1'b0, "R4 irq after reset", irq, 0);
    rd(A_ST, 16'h0, 1, "R5 status after reset");
    rd(A_CNT, 16'h0, 1, "R12 count after reset");

    // R1 / R4 / R11: count 3 to compare 5, continuous with interrupt
    tmr_pin = 1'b1; idle(4);
    wr(A_CA, 16'd5); wr(A_CTRL, 16'h3); wr(A_CNT, 16'd3); wr(A_CMD, GO);
    wait_irq(n);
    check(n == 2, "R1 first terminal edge", n, 2);
    check(wave_out === 1'b0, "R11 low after terminal", wave_out, 0);
    idle(1);
    check(irq === 1'b0, "R4 irq one cycle", irq, 0);
    check(wave_out === 1'b1, "R11 high again", wave_out, 1);
    wait_irq(n);
    check(n == 4, "R1 period equals compare", n + 1, 5);
    wr(A_CMD, HALT);
    rd(A_ST, 16'h1, 1, "R5 flag set, stopped");
    rd(A_ST, 16'h0, 1, "R5 flag cleared by read");

    // R2: compare 0 gives full range
    wr(A_CNT, 16'hFFFD); wr(A_CA, 16'h0); wr(A_CMD, GO);
    wait_irq(n);
    check(n == 3, "R2 wrap through 0xFFFF", n, 3);
    wr(A_CMD, HALT);
    rd(A_CNT, 16'h1, 1, "R2 count restarted at 0");

    // R3: single mode
    rd(A_ST, 16'h0, 0, "drain");
    wr(A_CA, 16'd4); wr(A_CTRL, 16'h2); wr(A_CNT, 16'h0); wr(A_CMD, GO);
    wait_irq(n);
    check(n == 4, "R3 single terminal edge", n, 4);
    idle(6);
    rd(A_ST, 16'h1, 1, "R3 single halted");
    rd(A_CNT, 16'h0, 1, "R3 single count zero");

    // R4: interrupt disabled, flag still set
    wr(A_CTRL, 16'h1); wr(A_CA, 16'd3); wr(A_CNT, 16'h0);
    rd(A_ST, 16'h0, 0, "drain");
    wr(A_CMD, GO);
    seen = 1'b0;
    repeat (10) begin @(negedge clk); if (irq) seen = 1'b1; end
    check(!seen, "R4 no irq when disabled", seen, 0);
    wr(A_CMD, HALT);
    rd(A_ST, 16'h1, 1, "R4 flag without irq");

    // R6: gate
    wr(A_CA, 16'd100); wr(A_CNT, 16'd10);
    tmr_pin = 1'b0; idle(4);
    wr(A_CMD, GO); idle(8); wr(A_CMD, HALT);
    rd(A_CNT, 16'd10, 1, "R6 gate low holds");
    tmr_pin = 1'b1; idle(4);
    wr(A_CMD, GO); idle(6); wr(A_CMD, HALT);
    rd(A_CNT, 16'd17, 1, "R6 gate high counts");

    // R7: retrigger
    tmr_pin = 1'b0; idle(4);
    wr(A_CTRL, 16'h21); wr(A_CA, 16'd1000); wr(A_CNT, 16'd50); wr(A_CMD, GO);
    idle(5);
    tmr_pin = 1'b1; idle(3);
    wr(A_CMD, HALT);
    rd(A_CNT, 16'd1, 1, "R7 retrigger reset");

    // R8: external clock
    tmr_pin = 1'b0; idle(4);
    wr(A_CTRL, 16'h5); wr(A_CNT, 16'h0); wr(A_CMD, GO);
    repeat (4) begin tmr_pin = 1'b1; idle(4); tmr_pin = 1'b0; idle(4); end
    idle(4); wr(A_CMD, HALT);
    rd(A_CNT, 16'd4, 1, "R8 counts pin edges");

    // R9: prescale tick
    tmr_pin = 1'b1; idle(4);
    wr(A_CTRL, 16'h11); wr(A_CNT, 16'h0); wr(A_CMD, GO);
    repeat (3) begin idle(3); pre_tick = 1'b1; idle(1); pre_tick = 1'b0; end
    idle(3); wr(A_CMD, HALT);
    rd(A_CNT, 16'd3, 1, "R9 counts prescale ticks");

    // R10: dual compare, bench model of the two phases
    wr(A_CTRL, 16'h0);
    ca = 16'd3; cb = 16'd2;
    wr(A_CA, ca); wr(A_CB, cb); wr(A_CNT, 16'h0); wr(A_CTRL, 16'h9); wr(A_CMD, GO);
    mcnt = 16'h0; mph = 1'b0;
    for (int i = 0; i < 15; i++) begin
      @(negedge clk);
      if (16'(mcnt + 16'd1) == (mph ? cb : ca)) begin mcnt = 16'h0; mph = ~mph; end
      else mcnt = mcnt + 16'd1;
      check(wave_out === ~mph, "R10 dual waveform", wave_out, ~mph);
    end
    wr(A_CMD, HALT); wr(A_CTRL, 16'h0);
    wr(A_CA, 16'd4); wr(A_CB, 16'd4); wr(A_CNT, 16'h0); wr(A_CTRL, 16'h9); wr(A_CMD, GO);
    highs = 0;
    repeat (16) begin @(negedge clk); if (wave_out) highs++; end
    check(highs == 8, "R10 equal compares 50%", highs, 8);
    wr(A_CMD, HALT); wr(A_CTRL, 16'h0);

    // R3: dual single stops after the low phase
    wr(A_CA, 16'd2); wr(A_CB, 16'd2); wr(A_CNT, 16'h0); wr(A_CTRL, 16'h8);
    rd(A_ST, 16'h0, 0, "drain");
    wr(A_CMD, GO); idle(12);
    rd(A_ST, 16'h1, 1, "R3 dual single halted high phase");
    check(wave_out === 1'b1, "R10 wave high after dual halt", wave_out, 1);

    // R12: count write while running
    wr(A_CTRL, 16'h1); wr(A_CA, 16'd1000); wr(A_CNT, 16'h0); wr(A_CMD, GO);
    idle(5); wr(A_CNT, 16'd500); wr(A_CMD, HALT);
    rd(A_CNT, 16'd501, 1, "R12 write while running");
    wr(A_CNT, 16'h1234);
    rd(A_CNT, 16'h1234, 1, "R12 write while stopped");

    // R13: readback
    rd(A_CTRL, 16'h1, 1, "R13 ctrl readback");
    rd(A_CA, 16'd1000, 1, "R13 compare A readback");
    rd(A_CB, 16'd2, 1, "R13 compare B readback");
    idle(3);
    check(sb_q.size() == 0, "R5 all reads returned", sb_q.size(), 0);
    done = 1'b1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (100000) @(posedge clk);
        check(1'b0, "watchdog expired", 0, 1);
      end
    join_any
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule